// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider

This block is the feedback divider of an integer-ratio frequency synthesizer loop. It runs on the fast (oscillator) clock. Three counters share the work: a prescaler counter that divides by P or P+1, a swallow counter (A) that picks the larger modulus for the first A prescaler periods of every output cycle, and a main counter (B) that counts prescaler periods until the output cycle ends. One output cycle therefore lasts A·(P+1) + (B−A)·P = B·P + A fast-clock cycles. The reference side of the loop has its own programmable divider and is not part of this block.

Software-side logic presents a 13-bit B value, a 5-bit A value and a 2-bit prescaler code together with a one-cycle load strobe. A valid setting is held in a pending copy and takes over only when the output cycle in progress ends. This means the loop never sees one short or stretched comparison period. A setting whose B is zero or smaller than A cannot be built from this counter scheme. Such a setting is refused and reported on an error flag.

Top module: `pulse_swallow_div`

## Requirements
- R1: While the setting is stable, `div_out` pulses once every N = B·P + A fast-clock cycles, counted from one pulse to the next.
- R2: `psel` picks the prescaler modulus P: code 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 64.
- R3: Each `div_out` pulse is exactly one clock cycle wide, so `div_out` is low in the cycle after a pulse.
- R4: The edge settings work without special cases. A = 0 gives exactly B·P. A = B gives B·(P+1). B = 1 with A = 0 gives the shortest ratio, P.
- R5: Synchronous reset clears `div_out` and `cfg_err`. It loads the setting B = 4, A = 1, code 0. The first pulse after reset is released appears on the 33rd rising edge.
- R6: A valid load does not change the output cycle in progress. The next pulse still comes after the old N, and the cycles after it use the new N.
- R7: A load with B = 0 or with B < A is ignored. The ratio in use is kept, and `cfg_err` is high from the clock edge that samples the strobe.
- R8: A valid load clears `cfg_err` at the clock edge that samples it. Without a load, `cfg_err` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, the signal being divided |
| rst | input | 1 | Synchronous active-high reset |
| b_val | input | 13 | Main counter value B (prescaler periods per output cycle) |
| a_val | input | 5 | Swallow count A (periods that use P+1) |
| psel | input | 2 | Prescaler modulus code (0:8, 1:16, 2:32, 3:64) |
| load | input | 1 | One-cycle strobe that samples b_val, a_val and psel |
| div_out | output | 1 | Divided output, one cycle high per N input cycles |
| cfg_err | output | 1 | High after a refused setting (B = 0 or B < A) |

## Verification
The bench goes after the edges of the swallow phase. A = 0 and A = B check that the swallow counter does not add a stray P+1 period or drop one; a design with an off-by-one in that counter is one cycle off the expected interval. The shortest ratio (B = 1, A = 0) and the largest code with A = B = 31 check the modulus reload at the frame boundary. Each load is placed just after a pulse, so a design that applies new values at once gives a wrong length for the cycle already under way. Refused settings (B < A, B = 0) must leave the interval unchanged and raise the flag. A reset in the middle of a cycle must restore the reset ratio.

// File: rtl/pswal_pkg.sv
package pswal_pkg;

  // prescaler modulus for a select code, given log2 of the smallest modulus
  function automatic int unsigned presc_mod(input int unsigned code,
                                            input int unsigned min_log2);
    return 32'd1 << (min_log2 + code);
  endfunction

  // a setting is usable only if the main count is non-zero and covers the swallow count
  function automatic logic setting_ok(input int unsigned b, input int unsigned a);
    return (b != 0) && (b >= a);
  endfunction

endpackage

// File: rtl/pswal_cfg.sv
module pswal_cfg #(
  parameter int B_W      = 13,
  parameter int A_W      = 5,
  parameter int PSEL_W   = 2,
  parameter int RST_B    = 4,
  parameter int RST_A    = 1,
  parameter int RST_PSEL = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [B_W-1:0]    b_in,
  input  logic [A_W-1:0]    a_in,
  input  logic [PSEL_W-1:0] psel_in,
  input  logic              frame_end,
  output logic [B_W-1:0]    pend_b,
  output logic [A_W-1:0]    pend_a,
  output logic [PSEL_W-1:0] pend_psel,
  output logic [PSEL_W-1:0] act_psel,
  output logic              cfg_err
);
  import pswal_pkg::*;

  logic in_ok;
  assign in_ok = setting_ok(int'(b_in), int'(a_in));

  // pending copy, written by a valid strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_b    <= B_W'(RST_B);
      pend_a    <= A_W'(RST_A);
      pend_psel <= PSEL_W'(RST_PSEL);
      cfg_err   <= 1'b0;
    end else if (load) begin
      if (in_ok) begin
        pend_b    <= b_in;
        pend_a    <= a_in;
        pend_psel <= psel_in;
        cfg_err   <= 1'b0;
      end else begin
        cfg_err   <= 1'b1;
      end
    end
  end

  // modulus code in force for the current output cycle
  always_ff @(posedge clk) begin
    if (rst)            act_psel <= PSEL_W'(RST_PSEL);
    else if (frame_end) act_psel <= pend_psel;
  end

endmodule

// File: rtl/pswal_presc.sv
module pswal_presc #(
  parameter int PSEL_W      = 2,
  parameter int P_MIN_LOG2  = 3,
  parameter int RST_PSEL    = 0,
  parameter int RST_SWALLOW = 1,
  localparam int NCODE      = 1 << PSEL_W,
  localparam int PC_W       = P_MIN_LOG2 + NCODE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PSEL_W-1:0] psel_next,
  input  logic              swallow_next,
  output logic              per_end
);
  import pswal_pkg::*;

  localparam logic [PC_W-1:0] RST_CNT =
    PC_W'(presc_mod(RST_PSEL, P_MIN_LOG2) + RST_SWALLOW - 1);

  logic [PC_W-1:0] mod_tab [NCODE];
  logic [PC_W-1:0] cnt;
  logic [PC_W-1:0] reload_val;

  // one modulus per select code
  for (genvar g = 0; g < NCODE; g++) begin : g_mod
    assign mod_tab[g] = PC_W'(presc_mod(g, P_MIN_LOG2));
  end

  // count down from modulus-1; modulus is P or P+1
  assign reload_val = mod_tab[psel_next] + PC_W'(swallow_next) - PC_W'(1);
  assign per_end    = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= RST_CNT;
    else if (per_end) cnt <= reload_val;
    else              cnt <= cnt - PC_W'(1);
  end

endmodule

// File: rtl/pswal_swallow.sv
module pswal_swallow #(
  parameter int B_W   = 13,
  parameter int A_W   = 5,
  parameter int RST_B = 4,
  parameter int RST_A = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           per_end,
  input  logic [B_W-1:0] pend_b,
  input  logic [A_W-1:0] pend_a,
  output logic           frame_end,
  output logic           swallow_next
);
  logic [B_W-1:0] b_left;
  logic [A_W-1:0] a_left;

  // the last prescaler period of an output cycle ends here
  assign frame_end = per_end && (b_left == B_W'(1));

  // modulus of the period that starts after this one
  assign swallow_next = frame_end ? (pend_a != '0) : (a_left > A_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      b_left <= B_W'(RST_B);
      a_left <= A_W'(RST_A);
    end else if (per_end) begin
      if (frame_end) begin
        b_left <= pend_b;
        a_left <= pend_a;
      end else begin
        b_left <= b_left - B_W'(1);
        if (a_left != '0) a_left <= a_left - A_W'(1);
      end
    end
  end

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
  parameter int B_W        = 13,
  parameter int A_W        = 5,
  parameter int PSEL_W     = 2,
  parameter int P_MIN_LOG2 = 3,
  parameter int RST_B      = 4,
  parameter int RST_A      = 1,
  parameter int RST_PSEL   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [B_W-1:0]    b_val,
  input  logic [A_W-1:0]    a_val,
  input  logic [PSEL_W-1:0] psel,
  input  logic              load,
  output logic              div_out,
  output logic              cfg_err
);
  localparam int RST_SWALLOW = (RST_A != 0) ? 1 : 0;

  logic [B_W-1:0]    pend_b;
  logic [A_W-1:0]    pend_a;
  logic [PSEL_W-1:0] pend_psel;
  logic [PSEL_W-1:0] act_psel;
  logic [PSEL_W-1:0] psel_next;
  logic              frame_end;
  logic              swallow_next;
  logic              per_end;

  pswal_cfg #(
    .B_W(B_W), .A_W(A_W), .PSEL_W(PSEL_W),
    .RST_B(RST_B), .RST_A(RST_A), .RST_PSEL(RST_PSEL)
  ) u_cfg (
    .clk(clk), .rst(rst), .load(load),
    .b_in(b_val), .a_in(a_val), .psel_in(psel),
    .frame_end(frame_end),
    .pend_b(pend_b), .pend_a(pend_a), .pend_psel(pend_psel),
    .act_psel(act_psel), .cfg_err(cfg_err)
  );

  // a new code starts with the first period of the next output cycle
  assign psel_next = frame_end ? pend_psel : act_psel;

  pswal_presc #(
    .PSEL_W(PSEL_W), .P_MIN_LOG2(P_MIN_LOG2),
    .RST_PSEL(RST_PSEL), .RST_SWALLOW(RST_SWALLOW)
  ) u_presc (
    .clk(clk), .rst(rst),
    .psel_next(psel_next), .swallow_next(swallow_next),
    .per_end(per_end)
  );

  pswal_swallow #(
    .B_W(B_W), .A_W(A_W), .RST_B(RST_B), .RST_A(RST_A)
  ) u_swallow (
    .clk(clk), .rst(rst), .per_end(per_end),
    .pend_b(pend_b), .pend_a(pend_a),
    .frame_end(frame_end), .swallow_next(swallow_next)
  );

  always_ff @(posedge clk) begin
    if (rst) div_out <= 1'b0;
    else     div_out <= frame_end;
  end

endmodule

// File: rtl/pswal_chk.sv
module pswal_chk #(
  parameter int B_W        = 13,
  parameter int A_W        = 5,
  parameter int PSEL_W     = 2,
  parameter int P_MIN_LOG2 = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [B_W-1:0]    b_val,
  input logic [A_W-1:0]    a_val,
  input logic [PSEL_W-1:0] psel,
  input logic              load,
  input logic              div_out,
  input logic              cfg_err
);
  localparam int MIN_N = 1 << P_MIN_LOG2;
  localparam int GAP_W = 16;

  logic           bad_in;
  logic [GAP_W-1:0] gap;

  assign bad_in = (b_val == '0) || (b_val < B_W'(a_val));

  // cycles since the last pulse (or since reset), saturating
  always_ff @(posedge clk) begin
    if (rst || div_out)  gap <= '0;
    else if (gap != '1)  gap <= gap + GAP_W'(1);
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    div_out |=> !div_out); // R3

  AST_PULSE_SPACING: assert property (@(posedge clk) disable iff (rst)
    div_out |-> (gap >= GAP_W'(MIN_N - 1))); // R1

  AST_BAD_LOAD_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (load && bad_in) |=> cfg_err); // R7

  AST_GOOD_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (load && !bad_in) |=> !cfg_err); // R8

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(cfg_err)); // R8

endmodule

bind pulse_swallow_div pswal_chk #(
  .B_W(B_W), .A_W(A_W), .PSEL_W(PSEL_W), .P_MIN_LOG2(P_MIN_LOG2)
) u_chk (
  .clk(clk), .rst(rst), .b_val(b_val), .a_val(a_val), .psel(psel),
  .load(load), .div_out(div_out), .cfg_err(cfg_err)
);

// File: tb/tb_pulse_swallow_div.sv
module tb_pulse_swallow_div;

  logic        clk = 1'b0;
  logic        rst;
  logic [12:0] b_val;
  logic [4:0]  a_val;
  logic [1:0]  psel;
  logic        load;
  logic        div_out;
  logic        cfg_err;

  int n_checks = 0;
  int n_fail   = 0;
  int cur_n;
  bit finished = 0;

  // {B[12:0], A[4:0], psel[1:0]}
  localparam int NVEC = 9;
  localparam logic [19:0] VEC [NVEC] = '{
    {13'd1,   5'd0,  2'd0},
    {13'd1,   5'd1,  2'd0},
    {13'd5,   5'd5,  2'd1},
    {13'd7,   5'd0,  2'd2},
    {13'd3,   5'd2,  2'd3},
    {13'd31,  5'd31, 2'd3},
    {13'd100, 5'd17, 2'd0},
    {13'd2,   5'd1,  2'd1},
    {13'd13,  5'd4,  2'd2}
  };

  pulse_swallow_div dut (
    .clk(clk), .rst(rst), .b_val(b_val), .a_val(a_val), .psel(psel),
    .load(load), .div_out(div_out), .cfg_err(cfg_err)
  );

  always #4 clk = ~clk;

  function automatic int exp_n(input int b, input int a, input int code);
    return b * (8 << code) + a;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // count negedges until div_out is seen high
  task automatic wait_pulse(input int start, output int n);
    n = start;
    do begin
      @(negedge clk);
      n++;
    end while (!div_out && n < 5000);
  endtask

  // drive a one-cycle strobe; returns one negedge later
  task automatic do_load(input int b, input int a, input int code);
    b_val = 13'(b); a_val = 5'(a); psel = 2'(code); load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    rst = 1'b1; load = 1'b0; b_val = '0; a_val = '0; psel = '0;
    repeat (3) @(negedge clk);
    check(div_out == 1'b0, "R5 div_out in reset", div_out, 0);
    check(cfg_err == 1'b0, "R5 cfg_err in reset", cfg_err, 0);
    rst = 1'b0;
    wait_pulse(0, n);
    check(n == 33, "R5 first pulse after reset", n, 33);
    cur_n = 33;

    // table walk: each load is placed right after a pulse
    for (int i = 0; i < NVEC; i++) begin
      int b, a, code, nn;
      b    = int'(VEC[i][19:7]);
      a    = int'(VEC[i][6:2]);
      code = int'(VEC[i][1:0]);
      nn   = exp_n(b, a, code);
      do_load(b, a, code);
      check(div_out == 1'b0, "R3 pulse one cycle wide", div_out, 0);
      check(cfg_err == 1'b0, "R8 valid load flag low", cfg_err, 0);
      wait_pulse(1, n);
      check(n == cur_n, "R6 cycle in progress keeps old N", n, cur_n);
      wait_pulse(0, n);
      check(n == nn, "R1 R2 R4 new ratio", n, nn);
      wait_pulse(0, n);
      check(n == nn, "R1 ratio repeats", n, nn);
      cur_n = nn;
    end

    // refused settings: B < A, then B = 0
    do_load(2, 3, 0);
    check(cfg_err == 1'b1, "R7 B<A flagged", cfg_err, 1);
    wait_pulse(1, n);
    check(n == cur_n, "R7 B<A ignored", n, cur_n);
    wait_pulse(0, n);
    check(n == cur_n, "R7 B<A ignored next cycle", n, cur_n);
    check(cfg_err == 1'b1, "R8 flag holds without load", cfg_err, 1);
    do_load(0, 0, 1);
    check(cfg_err == 1'b1, "R7 B=0 flagged", cfg_err, 1);
    wait_pulse(1, n);
    wait_pulse(0, n);
    check(n == cur_n, "R7 B=0 ignored", n, cur_n);

    // a valid load clears the flag
    do_load(2, 0, 0);
    check(cfg_err == 1'b0, "R8 valid load clears flag", cfg_err, 0);
    wait_pulse(1, n);
    check(n == cur_n, "R6 old N before boundary", n, cur_n);
    wait_pulse(0, n);
    check(n == 16, "R4 A=0 gives B*P", n, 16);
    cur_n = 16;

    // reset in the middle of a cycle with the flag raised
    do_load(3, 5, 0);
    check(cfg_err == 1'b1, "R7 flag before reset", cfg_err, 1);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(div_out == 1'b0, "R5 div_out cleared by reset", div_out, 0);
    check(cfg_err == 1'b0, "R5 cfg_err cleared by reset", cfg_err, 0);
    rst = 1'b0;
    wait_pulse(0, n);
    check(n == 33, "R5 reset ratio restored", n, 33);
    wait_pulse(0, n);
    check(n == 33, "R1 reset ratio repeats", n, 33);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule